// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte-wide meeting point between a host bus and the small microcontroller that runs a keyboard and mouse. The host reaches four registers through a single address line. A write with the line low deposits a data byte, and a write with the line high deposits a command byte. A read with the line low fetches the byte the controller left for the host, and a read with the line high returns a status byte. The controller side mirrors these accesses. It can take the deposited byte, leave a reply byte, set or clear an auxiliary flag, write three output port bits and fire a one-cycle strobe that switches on flag-driven interrupts.

Three flags tie the two sides together. An input-full flag is raised by any host write and dropped when the controller takes the byte. A command marker records which address the last host write used. An output-full flag is raised by a controller reply and dropped when the host reads data. The keyboard and mouse interrupt lines run in one of two modes, held in a two-state machine. In the direct state (`MODE_DIRECT`) they copy two port bits. After the enable strobe, the transition `GO_FLAGS` moves the machine to the flags state (`MODE_FLAGS`). From then on the keyboard line shows output-full and the mouse line shows the inverse of input-full, each gated by its port bit. Only reset leaves `MODE_FLAGS`. A third port bit drives a gate-A20 style output.

Top module: `kbm_mailbox`

## Requirements
- R1: A host write with `host_a`=0 stores the byte, which then appears on `ctl_ibuf_data`. It sets input-full (status bit 1) and clears the command marker (status bit 3).
- R2: A host write with `host_a`=1 stores the byte, sets input-full and sets the command marker.
- R3: `ctl_ibuf_rd` clears input-full on the next cycle. If a host write arrives in the same cycle, the write wins and input-full stays set.
- R4: `ctl_obuf_wr` stores a byte and sets output-full (status bit 0). A host read with `host_a`=0 returns that byte on `host_rdata` and clears output-full. If both happen in the same cycle, output-full stays set.
- R5: The status byte has output-full in bit 0, input-full in bit 1, the command marker in bit 3, the auxiliary flag in bit 5 and zero in every other bit. It appears on `ctl_status`, and on `host_rdata` during a host read with `host_a`=1. A status read changes no flag.
- R6: The auxiliary flag takes `ctl_aux_wdata` on `ctl_aux_wr`. Host reads of either register leave it unchanged.
- R7: In `MODE_DIRECT`, `kbd_irq` equals port bit 0 and `mouse_irq` equals port bit 1. The port bits are written from `ctl_port_wdata` on `ctl_port_wr`.
- R8: In `MODE_FLAGS`, `kbd_irq` is port bit 0 AND output-full, and `mouse_irq` is port bit 1 AND NOT input-full.
- R9: A one-cycle `ctl_flags_en` moves `MODE_DIRECT` to `MODE_FLAGS` on the next edge. Further strobes leave it in `MODE_FLAGS`, and only reset returns it to `MODE_DIRECT`.
- R10: `gate_a20` equals port bit 2.
- R11: Reset clears every flag, the port bits and the mode. As a result the status byte, `kbd_irq`, `mouse_irq` and `gate_a20` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_a | input | 1 | Host register select: 0 data, 1 command/status |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte |
| ctl_ibuf_rd | input | 1 | Controller takes the input byte |
| ctl_ibuf_data | output | DATA_W | Byte last written by the host |
| ctl_status | output | DATA_W | Status byte as seen by the controller |
| ctl_obuf_wr | input | 1 | Controller writes the reply byte |
| ctl_obuf_wdata | input | DATA_W | Reply byte |
| ctl_aux_wr | input | 1 | Controller writes the auxiliary flag |
| ctl_aux_wdata | input | 1 | New auxiliary flag value |
| ctl_port_wr | input | 1 | Controller writes the port bits |
| ctl_port_wdata | input | 3 | Port bits: 0 keyboard irq, 1 mouse irq, 2 gate |
| ctl_flags_en | input | 1 | One-cycle strobe that enables flags mode |
| kbd_irq | output | 1 | Keyboard interrupt |
| mouse_irq | output | 1 | Mouse interrupt |
| gate_a20 | output | 1 | Gate-A20 style output |

## Verification
The assertions check, on every cycle, the flag updates that follow each strobe. This covers who wins when a host write meets a controller read, and when a controller write meets a host data read. They also check that the auxiliary flag holds when it is not written, that `MODE_FLAGS` is entered and never left, and that the interrupt lines are low whenever flags mode gates them off. Some behaviour is shown only by the bench's scenarios, which compare every output against a bench model under directed and random traffic. This includes the exact status byte, the bytes carried in each direction, the absence of side effects from status reads, and the return of the interrupt lines to port control after a reset taken while in `MODE_FLAGS`.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
    typedef enum logic [0:0] {
        MODE_DIRECT = 1'b0,
        MODE_FLAGS  = 1'b1
    } mode_e;

    localparam int ST_OUT_FULL = 0;
    localparam int ST_IN_FULL  = 1;
    localparam int ST_CMD      = 3;
    localparam int ST_AUX      = 5;

    localparam int PORT_KBD   = 0;
    localparam int PORT_MOUSE = 1;
    localparam int PORT_GATE  = 2;
    localparam int PORT_W     = 3;
endpackage

// File: rtl/kbm_mode_fsm.sv
module kbm_mode_fsm
    import kbm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flags_en,
    output mode_e mode
);
    mode_e mode_q, mode_d;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_DIRECT;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_DIRECT: if (flags_en) mode_d = MODE_FLAGS;   // GO_FLAGS
            MODE_FLAGS:  mode_d = MODE_FLAGS;
            default:     mode_d = MODE_DIRECT;
        endcase
    end

    assign mode = mode_q;
endmodule

// File: rtl/kbm_in_buf.sv
module kbm_in_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_a,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              ctl_rd,
    output logic              in_full,
    output logic              cmd_flag,
    output logic [DATA_W-1:0] in_byte
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_full  <= 1'b0;
            cmd_flag <= 1'b0;
            in_byte  <= '0;
        end else if (host_wr) begin
            in_full  <= 1'b1;
            cmd_flag <= host_a;
            in_byte  <= host_wdata;
        end else if (ctl_rd) begin
            in_full  <= 1'b0;
        end
    end
endmodule

// File: rtl/kbm_out_buf.sv
module kbm_out_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              host_take,
    input  logic              aux_wr,
    input  logic              aux_wdata,
    output logic              out_full,
    output logic              aux_flag,
    output logic [DATA_W-1:0] out_byte
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_full <= 1'b0;
            out_byte <= '0;
        end else if (ctl_wr) begin
            out_full <= 1'b1;
            out_byte <= ctl_wdata;
        end else if (host_take) begin
            out_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      aux_flag <= 1'b0;
        else if (aux_wr) aux_flag <= aux_wdata;
    end
endmodule

// File: rtl/kbm_mailbox.sv
module kbm_mailbox
    import kbm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_a,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ctl_ibuf_rd,
    output logic [DATA_W-1:0] ctl_ibuf_data,
    output logic [DATA_W-1:0] ctl_status,
    input  logic              ctl_obuf_wr,
    input  logic [DATA_W-1:0] ctl_obuf_wdata,
    input  logic              ctl_aux_wr,
    input  logic              ctl_aux_wdata,
    input  logic              ctl_port_wr,
    input  logic [PORT_W-1:0] ctl_port_wdata,
    input  logic              ctl_flags_en,
    output logic              kbd_irq,
    output logic              mouse_irq,
    output logic              gate_a20
);
    logic              in_full, cmd_flag, out_full, aux_flag;
    logic [DATA_W-1:0] in_byte, out_byte;
    logic [PORT_W-1:0] port_q;
    mode_e             mode;
    logic              host_take;

    assign host_take = host_rd && !host_a;

    kbm_mode_fsm i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_en (ctl_flags_en),
        .mode     (mode)
    );

    kbm_in_buf #(.DATA_W(DATA_W)) i_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_a     (host_a),
        .host_wdata (host_wdata),
        .ctl_rd     (ctl_ibuf_rd),
        .in_full    (in_full),
        .cmd_flag   (cmd_flag),
        .in_byte    (in_byte)
    );

    kbm_out_buf #(.DATA_W(DATA_W)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_obuf_wr),
        .ctl_wdata (ctl_obuf_wdata),
        .host_take (host_take),
        .aux_wr    (ctl_aux_wr),
        .aux_wdata (ctl_aux_wdata),
        .out_full  (out_full),
        .aux_flag  (aux_flag),
        .out_byte  (out_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)           port_q <= '0;
        else if (ctl_port_wr) port_q <= ctl_port_wdata;
    end

    always_comb begin
        ctl_status              = '0;
        ctl_status[ST_OUT_FULL] = out_full;
        ctl_status[ST_IN_FULL]  = in_full;
        ctl_status[ST_CMD]      = cmd_flag;
        ctl_status[ST_AUX]      = aux_flag;
    end

    assign host_rdata    = host_a ? ctl_status : out_byte;
    assign ctl_ibuf_data = in_byte;

    always_comb begin
        gate_a20 = port_q[PORT_GATE];
        unique case (mode)
            MODE_DIRECT: begin
                kbd_irq   = port_q[PORT_KBD];
                mouse_irq = port_q[PORT_MOUSE];
            end
            MODE_FLAGS: begin
                kbd_irq   = port_q[PORT_KBD] & out_full;
                mouse_irq = port_q[PORT_MOUSE] & ~in_full;
            end
            default: begin
                kbd_irq   = 1'b0;
                mouse_irq = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/kbm_mailbox_chk.sv
module kbm_mailbox_chk
    import kbm_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  host_wr,
    input logic  host_rd,
    input logic  host_a,
    input logic  ctl_ibuf_rd,
    input logic  ctl_obuf_wr,
    input logic  ctl_aux_wr,
    input logic  ctl_port_wr,
    input logic  port_kbd_d,
    input logic  port_gate_d,
    input logic  ctl_flags_en,
    input logic  st_out,
    input logic  st_in,
    input logic  st_cmd,
    input logic  st_aux,
    input mode_e mode,
    input logic  kbd_irq,
    input logic  mouse_irq,
    input logic  gate_a20
);
    assert_data_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_a) |=> (st_in && !st_cmd));

    assert_cmd_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_a) |=> (st_in && st_cmd));

    assert_in_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ibuf_rd && !host_wr) |=> !st_in);

    assert_out_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_obuf_wr |=> st_out);

    assert_out_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_a && !ctl_obuf_wr) |=> !st_out);

    assert_aux_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_aux_wr |=> $stable(st_aux));

    assert_direct_kbd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIRECT && !ctl_flags_en && ctl_port_wr) |=> (kbd_irq == $past(port_kbd_d)));

    assert_flags_kbd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FLAGS && !st_out) |-> !kbd_irq);

    assert_flags_mouse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FLAGS && st_in) |-> !mouse_irq);

    assert_enter_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_flags_en |=> (mode == MODE_FLAGS));

    assert_stay_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FLAGS) |=> (mode == MODE_FLAGS));

    assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_port_wr |=> (gate_a20 == $past(port_gate_d)));
endmodule

bind kbm_mailbox kbm_mailbox_chk i_kbm_mailbox_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_a       (host_a),
    .ctl_ibuf_rd  (ctl_ibuf_rd),
    .ctl_obuf_wr  (ctl_obuf_wr),
    .ctl_aux_wr   (ctl_aux_wr),
    .ctl_port_wr  (ctl_port_wr),
    .port_kbd_d   (ctl_port_wdata[0]),
    .port_gate_d  (ctl_port_wdata[2]),
    .ctl_flags_en (ctl_flags_en),
    .st_out       (ctl_status[0]),
    .st_in        (ctl_status[1]),
    .st_cmd       (ctl_status[3]),
    .st_aux       (ctl_status[5]),
    .mode         (mode),
    .kbd_irq      (kbd_irq),
    .mouse_irq    (mouse_irq),
    .gate_a20     (gate_a20)
);

// File: tb/test_kbm_mailbox.sv
module test_kbm_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_wr, host_rd, host_a;
    logic [DW-1:0] host_wdata, host_rdata;
    logic          ctl_ibuf_rd;
    logic [DW-1:0] ctl_ibuf_data, ctl_status;
    logic          ctl_obuf_wr;
    logic [DW-1:0] ctl_obuf_wdata;
    logic          ctl_aux_wr, ctl_aux_wdata, ctl_port_wr;
    logic [2:0]    ctl_port_wdata;
    logic          ctl_flags_en;
    logic          kbd_irq, mouse_irq, gate_a20;

    int errors = 0;
    int checks = 0;

    // bench model, built from the requirements
    logic          m_in, m_out, m_cmd, m_aux, m_flags;
    logic [2:0]    m_port;
    logic [DW-1:0] m_ibyte, m_obyte;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbm_mailbox #(.DATA_W(DW)) i_kbm_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_a(host_a),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctl_ibuf_rd(ctl_ibuf_rd), .ctl_ibuf_data(ctl_ibuf_data),
        .ctl_status(ctl_status),
        .ctl_obuf_wr(ctl_obuf_wr), .ctl_obuf_wdata(ctl_obuf_wdata),
        .ctl_aux_wr(ctl_aux_wr), .ctl_aux_wdata(ctl_aux_wdata),
        .ctl_port_wr(ctl_port_wr), .ctl_port_wdata(ctl_port_wdata),
        .ctl_flags_en(ctl_flags_en),
        .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .gate_a20(gate_a20)
    );

    function automatic logic [DW-1:0] exp_status();
        return {2'b00, m_aux, 1'b0, m_cmd, 1'b0, m_in, m_out};
    endfunction

    function automatic logic exp_kbd();
        return m_flags ? (m_port[0] & m_out) : m_port[0];
    endfunction

    function automatic logic exp_mouse();
        return m_flags ? (m_port[1] & ~m_in) : m_port[1];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        host_wr = 0; host_rd = 0; host_a = 0; host_wdata = '0;
        ctl_ibuf_rd = 0; ctl_obuf_wr = 0; ctl_obuf_wdata = '0;
        ctl_aux_wr = 0; ctl_aux_wdata = 0; ctl_port_wr = 0;
        ctl_port_wdata = '0; ctl_flags_en = 0;
    endtask

    task automatic model_reset();
        m_in = 0; m_out = 0; m_cmd = 0; m_aux = 0; m_flags = 0;
        m_port = '0; m_ibyte = '0; m_obyte = '0;
    endtask

    // inputs are set after the falling edge; outputs checked, then one edge
    task automatic step();
        #1;
        chk("R5", ctl_status, exp_status());
        chk(m_flags ? "R8" : "R7", kbd_irq, exp_kbd());
        chk(m_flags ? "R8" : "R7", mouse_irq, exp_mouse());
        chk("R10", gate_a20, m_port[2]);
        chk(m_cmd ? "R2" : "R1", ctl_ibuf_data, m_ibyte);
        if (host_rd) chk(host_a ? "R5" : "R4", host_rdata, host_a ? exp_status() : m_obyte);
        @(posedge clk);
        if (host_wr) begin m_in = 1; m_cmd = host_a; m_ibyte = host_wdata; end
        else if (ctl_ibuf_rd) m_in = 0;
        if (ctl_obuf_wr) begin m_out = 1; m_obyte = ctl_obuf_wdata; end
        else if (host_rd && !host_a) m_out = 0;
        if (ctl_aux_wr) m_aux = ctl_aux_wdata;
        if (ctl_port_wr) m_port = ctl_port_wdata;
        if (ctl_flags_en) m_flags = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst_n = 0; idle_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1; model_reset();
        #1;
        chk("R11", ctl_status, 8'h00);
        chk("R11", kbd_irq, 0);
        chk("R11", mouse_irq, 0);
        chk("R11", gate_a20, 0);
    endtask

    task automatic random_run(input int n, input int flags_at);
        for (int i = 0; i < n; i++) begin
            int unsigned r;
            r = $urandom;
            case (r % 3)
                0: ;
                1: begin host_wr = 1; host_a = r[4]; host_wdata = DW'($urandom); end
                default: begin host_rd = 1; host_a = r[5]; end
            endcase
            ctl_ibuf_rd    = (r[9:8] == 2'b00);
            ctl_obuf_wr    = (r[11:10] == 2'b00);
            ctl_obuf_wdata = DW'($urandom);
            ctl_aux_wr     = (r[14:12] == 3'b000);
            ctl_aux_wdata  = r[15];
            ctl_port_wr    = (r[19:16] == 4'b0000);
            ctl_port_wdata = r[22:20];
            ctl_flags_en   = (i == flags_at);
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; idle_inputs(); model_reset();
        @(negedge clk);
        do_reset();

        host_wr = 1; host_a = 0; host_wdata = 8'hA5; step();
        #1; chk("R1", ctl_status, 8'h02); chk("R1", ctl_ibuf_data, 8'hA5);
        host_wr = 1; host_a = 1; host_wdata = 8'hD1; step();
        #1; chk("R2", ctl_status, 8'h0A); chk("R2", ctl_ibuf_data, 8'hD1);
        ctl_ibuf_rd = 1; host_wr = 1; host_a = 0; host_wdata = 8'h3C; step();
        #1; chk("R3", ctl_status, 8'h02);
        ctl_ibuf_rd = 1; step();
        #1; chk("R3", ctl_status, 8'h00);

        ctl_obuf_wr = 1; ctl_obuf_wdata = 8'h5A; step();
        #1; chk("R4", ctl_status, 8'h01);
        host_rd = 1; host_a = 1; step();
        #1; chk("R5", ctl_status, 8'h01);
        host_rd = 1; host_a = 0; #1; chk("R4", host_rdata, 8'h5A); step();
        #1; chk("R4", ctl_status, 8'h00);
        ctl_obuf_wr = 1; ctl_obuf_wdata = 8'h66; host_rd = 1; host_a = 0; step();
        #1; chk("R4", ctl_status, 8'h01);

        ctl_aux_wr = 1; ctl_aux_wdata = 1; step();
        #1; chk("R6", ctl_status, 8'h21);
        host_rd = 1; host_a = 0; step();
        #1; chk("R6", ctl_status, 8'h20);
        host_rd = 1; host_a = 1; step();
        #1; chk("R6", ctl_status, 8'h20);
        ctl_aux_wr = 1; ctl_aux_wdata = 0; step();
        #1; chk("R6", ctl_status, 8'h00);

        ctl_port_wr = 1; ctl_port_wdata = 3'b011; step();
        #1; chk("R7", {kbd_irq, mouse_irq, gate_a20}, 3'b110);
        ctl_port_wr = 1; ctl_port_wdata = 3'b100; step();
        #1; chk("R10", {kbd_irq, mouse_irq, gate_a20}, 3'b001);

        ctl_port_wr = 1; ctl_port_wdata = 3'b011; step();
        ctl_obuf_wr = 1; ctl_obuf_wdata = 8'h77; ctl_flags_en = 1; step();
        #1; chk("R9", {kbd_irq, mouse_irq}, 2'b11);
        host_rd = 1; host_a = 0; step();
        #1; chk("R8", kbd_irq, 0);
        host_wr = 1; host_a = 0; host_wdata = 8'h12; step();
        #1; chk("R8", mouse_irq, 0);
        ctl_ibuf_rd = 1; ctl_flags_en = 1; step();
        #1; chk("R9", mouse_irq, 1);
        ctl_port_wr = 1; ctl_port_wdata = 3'b000; step();
        #1; chk("R8", {kbd_irq, mouse_irq}, 2'b00);

        random_run(3000, -1);

        ctl_port_wr = 1; ctl_port_wdata = 3'b111; step();
        do_reset();
        ctl_port_wr = 1; ctl_port_wdata = 3'b011; step();
        #1; chk("R11", {kbd_irq, mouse_irq}, 2'b11);
        random_run(3000, 1000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule